// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block receives a stereo serial audio stream as a client. The bit clock, word-select line and data line come from an external master. They pass through synchronizers into the system clock domain, and each rising edge of the bit clock is detected there. The block then rebuilds left and right samples for four framing conventions: standard I2S, left-justified, right-justified, and a PCM/DSP style in which both channels follow a frame pulse one after the other.

The framing convention and the sample width are static selects, changed only while reset is held. Each finished word appears for one system clock on a 32-bit data output with a valid strobe. A channel tag says whether the word is left or right, and the sample sits in the low bits of the data output. If the word-select line changes before the current word has all its bits, the partial word is dropped and a one-cycle error pulse is raised. Bit slots that carry no sample data are skipped.

Top module: `serial_audio_rx`

## Requirements
- R1: The SCK, LRC and SDI pins each pass through a two-flop synchronizer. SDI and LRC are sampled on each rising SCK edge seen after synchronization, and sample bits arrive MSB first.
- R2: The format select takes 0 = I2S, 1 = left-justified, 2 = right-justified and 3 = PCM/DSP. The width select takes 0 = 16, 1 = 20, 2 = 24 and 3 = 32 bits, written N below. Each word is output right-aligned in `smp_data_o`, and every bit above N is zero.
- R3: In I2S, the MSB is the sample taken at the second rising SCK edge after an LRC change, and the next N-1 samples follow it. LRC low tags the word as left (`smp_right_o` = 0). N SCK cycles per channel are enough: the LSB may be the first sample after the next LRC change.
- R4: In left-justified format, the MSB is the first sample that shows the new LRC level. LRC high tags the word as left.
- R5: In right-justified format, the word is emitted when LRC changes. It holds the last N samples of the period that just ended, and any earlier samples in that period are ignored. The tag comes from the LRC level of the ended period, with high meaning left.
- R6: In PCM/DSP format, a frame starts at a sample where LRC has gone from low to high. The left MSB is the next sample, and the right MSB comes straight after the left LSB. A falling edge on LRC, and the width of the LRC pulse, have no effect.
- R7: Samples outside the word windows of R3 to R6 leave the emitted words unchanged.
- R8: An LRC boundary that arrives before enough samples have been taken raises `frame_err_o` for one cycle, and the incomplete word is never emitted. Enough means N samples per period for I2S, left-justified and right-justified, and 2N+1 samples per frame for PCM/DSP.
- R9: After reset, nothing is emitted and no error is raised until the first LRC boundary.
- R10: `smp_valid_o` is a one-cycle pulse. It follows the sys-clock edge at which the last bit is sampled, and it never coincides with `frame_err_o`.
- R11: During and right after reset, `smp_valid_o`, `smp_right_o`, `frame_err_o` and `smp_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| fmt_i | input | 2 | Framing convention select (static) |
| wsel_i | input | 2 | Sample width select (static) |
| sck_i | input | 1 | External serial bit clock |
| lrc_i | input | 1 | External word-select / frame line |
| sdi_i | input | 1 | External serial data |
| smp_valid_o | output | 1 | One-cycle strobe for a finished word |
| smp_data_o | output | 32 | Received sample, right-aligned |
| smp_right_o | output | 1 | Channel tag: 1 = right, 0 = left |
| frame_err_o | output | 1 | One-cycle pulse on a cut-short word |

## Verification
The assertions assume that SCK is slow enough compared with the system clock for every high and low phase to be seen after synchronization. They also assume that SDI and LRC settle well before the SCK rising edge they are sampled on, and that the format and width selects change only in reset. The stimulus holds each SCK phase for four system clocks and changes SDI and LRC only at the start of the low phase. It applies a new format or width only inside a reset sequence. Under these conditions the output strobes are isolated pulses that always trace back to a detected SCK edge.

// File: rtl/sarx_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the serial audio receiver.
// Assumes the width select never asks for more bits than the output holds.
package sarx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_PCM = 2'd3
    } sarx_fmt_e;

    // Map the width select code to a bit count.
    function automatic int unsigned sarx_width(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/sarx_sync_bit.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for one asynchronous pin.
// Assumes the pin is a level (not a pulse) that stays put for many clocks.
module sarx_sync_bit #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sarx_edge.sv
`timescale 1ns/1ps
// Rising-edge detector on the synchronized bit clock.
// Assumes the input is already in the system clock domain.
module sarx_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);

    logic lvl_d_q;

    // Keep the previous level for edge comparison.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lvl_d_q <= 1'b0;
        end else begin
            lvl_d_q <= lvl_i;
        end
    end

    assign rise_o = lvl_i & ~lvl_d_q;

endmodule

// File: rtl/sarx_deser.sv
`timescale 1ns/1ps
// Frame tracker and deserializer. On each bit strobe it takes one data
// sample and one LRC sample, finds LRC boundaries for the chosen format,
// indexes the sample within its period and assembles words MSB first.
// Assumes fmt_i and wsel_i are static outside reset and that the width
// never exceeds DW.
module sarx_deser
    import sarx_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    fmt_i,
    input  logic [1:0]    wsel_i,
    input  logic          stb_i,
    input  logic          bit_i,
    input  logic          lrc_i,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output logic          right_o,
    output logic          err_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    sarx_fmt_e     fmt_w;
    logic [CW-1:0] n_w, first_w, end_l_w, end_r_w, need_w, idx_w;
    logic [DW-1:0] mask_w, acc_nxt_w, out_data_w;
    logic          is_i2s_w, is_lj_w, is_rj_w, is_pcm_w;
    logic          boundary_w, live_w, in_l_w, in_r_w, grab_w, tail_w;
    logic          word_done_w, rj_done_w, short_w, emit_w, out_right_w;

    logic          seen_q, synced_q, lrc_last_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] acc_q, rj_q;
    logic          valid_q, right_q, err_q;
    logic [DW-1:0] data_q;

    // Decode the format and derive the word windows for the current width.
    always_comb begin
        fmt_w    = sarx_fmt_e'(fmt_i);
        is_i2s_w = (fmt_w == FMT_I2S);
        is_lj_w  = (fmt_w == FMT_LJ);
        is_rj_w  = (fmt_w == FMT_RJ);
        is_pcm_w = (fmt_w == FMT_PCM);
        n_w      = CW'(sarx_width(wsel_i));
        first_w  = (is_i2s_w || is_pcm_w) ? CW'(1) : '0;
        end_l_w  = first_w + n_w;
        end_r_w  = end_l_w + n_w;
        need_w   = is_pcm_w ? end_r_w : n_w;
        mask_w   = ~({DW{1'b1}} << n_w);
    end

    // Locate the current sample relative to the last LRC boundary.
    always_comb begin
        if (is_pcm_w) begin
            boundary_w = seen_q && lrc_i && !lrc_last_q;
        end else begin
            boundary_w = seen_q && (lrc_i != lrc_last_q);
        end
        idx_w   = boundary_w ? '0 : cnt_q;
        live_w  = synced_q || boundary_w;
        in_l_w  = (idx_w >= first_w) && (idx_w < end_l_w);
        in_r_w  = is_pcm_w && (idx_w >= end_l_w) && (idx_w < end_r_w);
    end

    // Decide capture, completion and error events for this strobe.
    always_comb begin
        grab_w      = stb_i && live_w && (in_l_w || in_r_w) && !is_rj_w;
        tail_w      = stb_i && is_i2s_w && boundary_w && synced_q && (cnt_q == n_w);
        word_done_w = grab_w && ((idx_w == end_l_w - CW'(1)) ||
                                 (is_pcm_w && (idx_w == end_r_w - CW'(1))));
        rj_done_w   = stb_i && is_rj_w && boundary_w && synced_q && (cnt_q >= n_w);
        short_w     = stb_i && boundary_w && synced_q && (cnt_q < need_w);
        if ((idx_w == first_w && !boundary_w) || (is_pcm_w && idx_w == end_l_w)) begin
            acc_nxt_w = {{(DW-1){1'b0}}, bit_i};
        end else begin
            acc_nxt_w = {acc_q[DW-2:0], bit_i};
        end
    end

    // Select the word and channel tag to publish.
    always_comb begin
        emit_w      = word_done_w || tail_w || rj_done_w;
        out_data_w  = acc_nxt_w & mask_w;
        out_right_w = 1'b0;
        if (rj_done_w) begin
            out_data_w  = rj_q & mask_w;
            out_right_w = ~lrc_last_q;
        end else if (tail_w) begin
            out_right_w = lrc_last_q;
        end else if (is_i2s_w) begin
            out_right_w = lrc_i;
        end else if (is_lj_w) begin
            out_right_w = ~lrc_i;
        end else begin
            out_right_w = in_r_w;
        end
    end

    // Track framing state and shift in each sampled bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q     <= 1'b0;
            synced_q   <= 1'b0;
            lrc_last_q <= 1'b0;
            cnt_q      <= '0;
            acc_q      <= '0;
            rj_q       <= '0;
        end else if (stb_i) begin
            seen_q     <= 1'b1;
            lrc_last_q <= lrc_i;
            rj_q       <= {rj_q[DW-2:0], bit_i};
            if (boundary_w) begin
                synced_q <= 1'b1;
                cnt_q    <= CW'(1);
            end else if (cnt_q != CNT_MAX) begin
                cnt_q    <= cnt_q + CW'(1);
            end
            if (grab_w || tail_w) begin
                acc_q <= acc_nxt_w;
            end
        end
    end

    // Register the output strobe, word, tag and error pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            right_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= emit_w;
            err_q   <= short_w;
            if (emit_w) begin
                data_q  <= out_data_w;
                right_q <= out_right_w;
            end
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign right_o = right_q;
    assign err_o   = err_q;

endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
// Client-mode stereo serial audio receiver. Synchronizes the three serial
// pins, detects bit clock rising edges and hands each sampled bit to the
// deserializer, which emits tagged words and framing errors.
// Assumes SCK phases each last at least two system clocks and that SDI/LRC
// are stable around the SCK rising edge.
module serial_audio_rx #(
    parameter int unsigned DW          = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CW          = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    fmt_i,
    input  logic [1:0]    wsel_i,
    input  logic          sck_i,
    input  logic          lrc_i,
    input  logic          sdi_i,
    output logic          smp_valid_o,
    output logic [DW-1:0] smp_data_o,
    output logic          smp_right_o,
    output logic          frame_err_o
);

    localparam int unsigned NPINS = 3;

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_syn;
    logic             sck_rise;

    assign pins_raw = {sdi_i, lrc_i, sck_i};

    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        sarx_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (pins_raw[g]),
            .q_o    (pins_syn[g])
        );
    end

    sarx_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (pins_syn[0]),
        .rise_o (sck_rise)
    );

    sarx_deser #(.DW(DW), .CW(CW)) u_deser (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fmt_i   (fmt_i),
        .wsel_i  (wsel_i),
        .stb_i   (sck_rise),
        .bit_i   (pins_syn[2]),
        .lrc_i   (pins_syn[1]),
        .valid_o (smp_valid_o),
        .data_o  (smp_data_o),
        .right_o (smp_right_o),
        .err_o   (frame_err_o)
    );

endmodule

// File: rtl/sarx_chk.sv
`timescale 1ns/1ps
// Property checker for the serial audio receiver, bound to the top.
// Assumes the bit strobe input is the detected SCK rising edge.
module sarx_chk
    import sarx_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    wsel_i,
    input  logic          stb_i,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    input  logic          err_i
);

    logic [DW-1:0] mask_w;
    assign mask_w = ~({DW{1'b1}} << sarx_width(wsel_i));

    // R10
    valid_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_i && err_i));

    // R10
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> !valid_i);

    // R10
    valid_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |-> $past(stb_i));

    // R8
    err_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |-> $past(stb_i));

    // R2
    upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |-> ((data_i & ~mask_w) == '0));

endmodule

bind serial_audio_rx sarx_chk #(.DW(DW)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wsel_i  (wsel_i),
    .stb_i   (sck_rise),
    .valid_i (smp_valid_o),
    .data_i  (smp_data_o),
    .err_i   (frame_err_o)
);

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;

    localparam logic [1:0] F_I2S = 2'd0;
    localparam logic [1:0] F_LJ  = 2'd1;
    localparam logic [1:0] F_RJ  = 2'd2;
    localparam logic [1:0] F_PCM = 2'd3;
    localparam int NV = 10;

    // {fmt, wsel, left stimulus, right stimulus, expected left, expected right}
    localparam logic [131:0] VEC [NV] = '{
        {F_I2S, 2'd0, 32'hDEADA5C3, 32'h12343C5A, 32'h0000A5C3, 32'h00003C5A},
        {F_I2S, 2'd3, 32'h80000001, 32'h7FFFFFFE, 32'h80000001, 32'h7FFFFFFE},
        {F_LJ,  2'd2, 32'hFF9ABCDE, 32'h00123456, 32'h009ABCDE, 32'h00123456},
        {F_LJ,  2'd1, 32'h000F0F0F, 32'hABC80001, 32'h000F0F0F, 32'h00080001},
        {F_RJ,  2'd0, 32'h0000FFFF, 32'h00008001, 32'h0000FFFF, 32'h00008001},
        {F_RJ,  2'd2, 32'h11C0FFEE, 32'h22000001, 32'h00C0FFEE, 32'h00000001},
        {F_RJ,  2'd3, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'hA5A5A5A5, 32'h5A5A5A5A},
        {F_PCM, 2'd0, 32'h0000BEEF, 32'h0000F00D, 32'h0000BEEF, 32'h0000F00D},
        {F_PCM, 2'd3, 32'hCAFEBABE, 32'h0BADF00D, 32'hCAFEBABE, 32'h0BADF00D},
        {F_PCM, 2'd1, 32'h000ABCDE, 32'hFFF12345, 32'h000ABCDE, 32'h00012345}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  wsel = 2'd0;
    logic        sck = 1'b0;
    logic        lrc = 1'b0;
    logic        sdi = 1'b0;
    logic        smp_valid;
    logic [31:0] smp_data;
    logic        smp_right;
    logic        frame_err;

    int tests = 0;
    int fails = 0;
    int err_cnt = 0;
    int dbl_cnt = 0;
    logic prev_valid = 1'b0;
    logic [32:0] got_q [$];

    always #4 clk = ~clk;

    serial_audio_rx dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .fmt_i       (fmt),
        .wsel_i      (wsel),
        .sck_i       (sck),
        .lrc_i       (lrc),
        .sdi_i       (sdi),
        .smp_valid_o (smp_valid),
        .smp_data_o  (smp_data),
        .smp_right_o (smp_right),
        .frame_err_o (frame_err)
    );

    // Collect emitted words and error pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_valid) got_q.push_back({smp_right, smp_data});
            if (frame_err) err_cnt++;
            if ((smp_valid && prev_valid) || (smp_valid && frame_err)) dbl_cnt++;
            prev_valid <= smp_valid;
        end else begin
            prev_valid <= 1'b0;
        end
    end

    function automatic int width_of(input logic [1:0] w);
        case (w)
            2'd0: return 16;
            2'd1: return 20;
            2'd2: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] f);
        case (f)
            F_I2S: return "R3 (R1,R2,R7)";
            F_LJ:  return "R4 (R1,R2,R7)";
            F_RJ:  return "R5 (R1,R2,R7)";
            default: return "R6 (R1,R2,R7)";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
        @(negedge clk);
        rst_n = 1'b0; fmt = f; wsel = w; sck = 1'b0; lrc = 1'b0; sdi = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        got_q.delete();
        err_cnt = 0;
    endtask

    // One SCK period: data and LRC change with the low phase.
    task automatic slot(input logic lv, input logic dv);
        @(negedge clk);
        sck = 1'b0; lrc = lv; sdi = dv;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [1:0] f, input int n, input int per,
                              input logic [31:0] lv, input logic [31:0] rv);
        int s0;
        int s1;
        logic lr;
        logic d;
        for (int i = 0; i < 3; i++) slot(f == F_I2S, 1'b1);
        case (f)
            F_I2S:   begin s0 = 1;       s1 = per + 1;     end
            F_LJ:    begin s0 = 0;       s1 = per;         end
            F_RJ:    begin s0 = per - n; s1 = 2 * per - n; end
            default: begin s0 = 1;       s1 = 1 + n;       end
        endcase
        for (int s = 0; s < 2 * per + 1; s++) begin
            if (f == F_PCM)      lr = (s == 0);
            else if (f == F_I2S) lr = (s >= per) && (s < 2 * per);
            else                 lr = (s < per) || (s == 2 * per);
            d = 1'b1;
            if (s >= s0 && s < s0 + n)      d = lv[n - 1 - (s - s0)];
            else if (s >= s1 && s < s1 + n) d = rv[n - 1 - (s - s1)];
            slot(lr, d);
        end
    endtask

    task automatic settle();
        repeat (16) @(negedge clk);
    endtask

    initial begin
        // R11: reset state
        do_reset(F_I2S, 2'd0);
        @(negedge clk);
        check("R11", "outputs after reset",
              {29'd0, smp_valid, frame_err, smp_right, smp_data}, 64'd0);

        // Table walk: one full stereo frame per format/width
        for (int v = 0; v < NV; v++) begin
            logic [131:0] e;
            logic [32:0]  w0;
            logic [32:0]  w1;
            e = VEC[v];
            do_reset(e[131:130], e[129:128]);
            send_frame(e[131:130], width_of(e[129:128]), 32, e[127:96], e[95:64]);
            settle();
            w0 = (got_q.size() > 0) ? got_q[0] : '1;
            w1 = (got_q.size() > 1) ? got_q[1] : '1;
            check(req_of(e[131:130]), "word count", 64'(got_q.size()), 64'd2);
            check(req_of(e[131:130]), "left word", 64'(w0), 64'({1'b0, e[63:32]}));
            check(req_of(e[131:130]), "right word", 64'(w1), 64'({1'b1, e[31:0]}));
            check("R8", "no error on full frame", 64'(err_cnt), 64'd0);
        end

        // R9: no output before the first LRC boundary
        do_reset(F_LJ, 2'd0);
        for (int i = 0; i < 40; i++) slot(1'b1, i[0]);
        settle();
        check("R9", "words before boundary", 64'(got_q.size()), 64'd0);
        check("R9", "errors before boundary", 64'(err_cnt), 64'd0);

        // R3: I2S with exactly N SCK per channel, LSB after LRC change
        do_reset(F_I2S, 2'd0);
        send_frame(F_I2S, 16, 16, 32'h0000C001, 32'h00007FF3);
        settle();
        check("R3", "min-clock word count", 64'(got_q.size()), 64'd2);
        check("R3", "min-clock left", 64'((got_q.size() > 0) ? got_q[0] : '1),
              64'({1'b0, 32'h0000C001}));
        check("R3", "min-clock right", 64'((got_q.size() > 1) ? got_q[1] : '1),
              64'({1'b1, 32'h00007FF3}));

        // R8: I2S left period cut short
        do_reset(F_I2S, 2'd0);
        for (int i = 0; i < 3; i++) slot(1'b1, 1'b1);
        for (int i = 0; i < 9; i++) slot(1'b0, 1'b0);
        slot(1'b1, 1'b1);
        for (int i = 15; i >= 0; i--) slot(1'b1, i[0] ^ i[2]);
        for (int i = 0; i < 15; i++) slot(1'b1, 1'b1);
        slot(1'b0, 1'b1);
        settle();
        check("R8", "I2S short error count", 64'(err_cnt), 64'd1);
        check("R8", "I2S short words", 64'(got_q.size()), 64'd1);
        check("R8", "I2S surviving right", 64'((got_q.size() > 0) ? got_q[0] : '1),
              64'({1'b1, 32'h00005A5A}));

        // R8: right-justified period cut short
        do_reset(F_RJ, 2'd0);
        for (int i = 0; i < 3; i++) slot(1'b0, 1'b1);
        for (int i = 0; i < 10; i++) slot(1'b1, 1'b0);
        for (int i = 0; i < 16; i++) slot(1'b0, 1'b1);
        for (int i = 15; i >= 0; i--) slot(1'b0, (i < 4));
        slot(1'b1, 1'b0);
        settle();
        check("R8", "RJ short error count", 64'(err_cnt), 64'd1);
        check("R5", "RJ leading slots ignored", 64'((got_q.size() > 0) ? got_q[0] : '1),
              64'({1'b1, 32'h0000000F}));

        // R6: PCM with a wide LRC pulse falling mid-word
        do_reset(F_PCM, 2'd0);
        for (int i = 0; i < 3; i++) slot(1'b0, 1'b1);
        slot(1'b1, 1'b1);
        for (int i = 15; i >= 0; i--) slot(i > 6, i[1]);
        for (int i = 15; i >= 0; i--) slot(1'b0, ~i[0]);
        for (int i = 0; i < 31; i++) slot(1'b0, 1'b1);
        settle();
        check("R6", "wide pulse word count", 64'(got_q.size()), 64'd2);
        check("R6", "wide pulse left", 64'((got_q.size() > 0) ? got_q[0] : '1),
              64'({1'b0, 32'h0000CCCC}));
        check("R6", "wide pulse right", 64'((got_q.size() > 1) ? got_q[1] : '1),
              64'({1'b1, 32'h00005555}));
        check("R6", "wide pulse no error", 64'(err_cnt), 64'd0);

        // R8: PCM frame restarted before the right word completes
        do_reset(F_PCM, 2'd0);
        for (int i = 0; i < 3; i++) slot(1'b0, 1'b1);
        slot(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) slot(1'b0, 1'b0);
        send_frame(F_PCM, 16, 32, 32'h00001234, 32'h00005678);
        settle();
        check("R8", "PCM short error count", 64'(err_cnt), 64'd1);
        check("R8", "PCM short word count", 64'(got_q.size()), 64'd3);

        check("R10", "strobe overlap or double pulse", 64'(dbl_cnt), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule